// File: doc/BRIEF.md
# Poison-Aware SEC-DED Check Station

This block sits on the data path between two levels of a memory hierarchy. On the write side it produces the check byte for a data word using an extended Hamming code: Hamming check bits plus an overall parity bit. When the word being written is already known to be bad, it folds a fixed mask into the check byte. On the read side it takes a stored word and its check byte and computes the syndrome. It corrects any single flipped bit and flags any double flip as uncorrectable. It also recognises words that were stored with the mask. Each read yields the repaired data, a two-bit status, and a fresh check byte for the next level. Uncorrectable words and masked words leave the station with the mask applied again, so the next level also sees them as known-bad.

A small fault-capture register records corrected and uncorrectable events in sticky bits. It holds the syndrome of the first error that reaches an empty register. A masked word is treated as already reported, so it changes nothing in this register. Software-side handling is outside the block; it clears the sticky bits through a write-one-to-clear input.

Top module: `ecc_sue_station`

## Requirements
- R1: `wr_chk` is a combinational function of `wr_data`. Bits 6:0 are Hamming check bits. Bit k covers every Hamming position whose bit k is set. Check bit k occupies position 2^k. Data bit i occupies the i-th position, counting upward from 3, that is not a power of two. Bit 7 makes the parity over all 64 data bits and all 8 check bits even.
- R2: With `wr_poison` high, `wr_chk` equals the R1 value XOR 8'h7F.
- R3: A read presented with `rd_valid` high appears on the outputs after the next rising clock edge, with `out_valid` high. A clean word gives `out_stat` = 2'b00, unchanged data, and `out_chk` equal to the R1 encoding of that data.
- R4: A single flip of any of the 72 stored bits gives `out_stat` = 2'b01. The outputs then carry the original data and its R1 check byte.
- R5: Any two flipped bits give `out_stat` = 2'b10. The data passes on uncorrected, and `out_chk` is the R1 encoding of that data XOR 8'h7F.
- R6: A word stored with the R2 mask gives `out_stat` = 2'b11, with the data unchanged and `out_chk` equal to R1 XOR 8'h7F. It leaves the fault-capture register unchanged.
- R7: A masked word with one additional flipped bit gives `out_stat` = 2'b10 and never 2'b01.
- R8: Status 01 sets the sticky bit `fir_ce`, and status 10 sets the sticky bit `fir_ue`. `fir_syn` is {overall parity mismatch, 7-bit Hamming syndrome}. It is captured only when the register would otherwise be empty, and is held while either sticky bit stays set.
- R9: `fir_clr[0]` clears `fir_ce` and `fir_clr[1]` clears `fir_ue`. A new event in the same cycle wins over the clear. `fir_syn` returns to zero when both sticky bits end up clear.
- R10: While `rd_valid` is low, `out_valid` is low after the next edge and the fault-capture register does not change.
- R11: During reset, `out_valid`, `out_stat`, `fir_ce`, `fir_ue` and `fir_syn` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 64 | Data word to be encoded |
| wr_poison | input | 1 | Marks the write data as known-bad |
| wr_chk | output | 8 | Check byte for the write data |
| rd_valid | input | 1 | A read word is present |
| rd_data | input | 64 | Stored data word |
| rd_chk | input | 8 | Stored check byte |
| out_valid | output | 1 | Read result valid |
| out_data | output | 64 | Corrected or passed-through data |
| out_chk | output | 8 | Check byte for the next level |
| out_stat | output | 2 | 00 clean, 01 corrected, 10 new uncorrectable, 11 stored known-bad |
| fir_clr | input | 2 | Write-one-to-clear for the sticky bits |
| fir_ce | output | 1 | Sticky corrected-error bit |
| fir_ue | output | 1 | Sticky uncorrectable-error bit |
| fir_syn | output | 8 | Syndrome of the first captured error |

## Verification
The in-RTL properties check, on every cycle, how the read status relates to the fault-capture register. A sticky bit can only rise together with the matching status. A masked word must leave the register untouched. A captured syndrome is nonzero and stays put while it is held. These properties cannot show that the syndrome arithmetic is right. The bench scenarios cover that part. They flip every one of the 72 stored bits, every pair of bits, and every single bit on top of a masked word, and compare each result with an independently written encoder. They also cover the capture, clear and set-wins sequences.

// File: rtl/ecc_sue_pkg.sv
package ecc_sue_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_NEWUE = 2'b10,
    ST_SUE   = 2'b11
  } ecc_stat_e;

  // Hamming check bits: leave at least one unused position so that the
  // all-ones syndrome can mark known-bad data.
  function automatic int hbits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 2) p++;
    return p;
  endfunction

  // Codeword position of data bit idx: the idx-th non-power-of-two from 3 up.
  function automatic int data_pos(input int idx);
    int p;
    int n;
    p = 2;
    n = -1;
    while (n < idx) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

endpackage

// File: rtl/ecc_sue_enc.sv
module ecc_sue_enc
  import ecc_sue_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P  = hbits(DATA_W),
  localparam int CW = P + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              poison_i,
  output logic [CW-1:0]     chk_o
);
  // Mask: all Hamming bits set; top bit chosen so the mask has odd weight.
  localparam logic        MASK_TOP = ((P % 2) == 0);
  localparam logic [CW-1:0] MASK   = {MASK_TOP, {P{1'b1}}};

  logic [P-1:0] contrib [DATA_W];
  logic [P-1:0] ham;
  logic         par;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_col
    localparam logic [P-1:0] POS_V = P'(data_pos(gi));
    assign contrib[gi] = data_i[gi] ? POS_V : '0;
  end

  always_comb begin
    ham = '0;
    for (int i = 0; i < DATA_W; i++) ham ^= contrib[i];
  end

  assign par   = (^data_i) ^ (^ham);
  assign chk_o = {par, ham} ^ (poison_i ? MASK : '0);

endmodule

// File: rtl/ecc_sue_dec.sv
module ecc_sue_dec
  import ecc_sue_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P  = hbits(DATA_W),
  localparam int CW = P + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CW-1:0]     chk_i,
  output logic [DATA_W-1:0] data_o,
  output ecc_stat_e         stat_o,
  output logic [CW-1:0]     syn_o
);
  localparam logic [P-1:0] LAST_POS = P'(DATA_W + P);
  localparam logic [P-1:0] SUE_SYN  = {P{1'b1}};

  logic [CW-1:0]     regen;
  logic [P-1:0]      s;
  logic              pm;
  logic [DATA_W-1:0] flip;

  ecc_sue_enc #(.DATA_W(DATA_W)) u_regen (
    .data_i   (data_i),
    .poison_i (1'b0),
    .chk_o    (regen)
  );

  assign s     = regen[P-1:0] ^ chk_i[P-1:0];
  assign pm    = (^data_i) ^ (^chk_i);
  assign syn_o = {pm, s};

  always_comb begin
    if (!pm && s == '0)          stat_o = ST_CLEAN;
    else if (pm && s == SUE_SYN) stat_o = ST_SUE;
    else if (pm && s <= LAST_POS) stat_o = ST_FIXED;
    else                         stat_o = ST_NEWUE;
  end

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_fix
    localparam logic [P-1:0] POS_V = P'(data_pos(gi));
    assign flip[gi] = (stat_o == ST_FIXED) && (s == POS_V);
  end

  assign data_o = data_i ^ flip;

endmodule

// File: rtl/ecc_sue_fir.sv
module ecc_sue_fir #(
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_ce,
  input  logic             ev_ue,
  input  logic [SYN_W-1:0] ev_syn,
  input  logic [1:0]       clr,
  output logic             ce,
  output logic             ue,
  output logic [SYN_W-1:0] syn
);
  logic kept_ce, kept_ue, nxt_ce, nxt_ue, first_hit;

  assign kept_ce   = ce & ~clr[0];
  assign kept_ue   = ue & ~clr[1];
  assign nxt_ce    = kept_ce | ev_ce;
  assign nxt_ue    = kept_ue | ev_ue;
  assign first_hit = !kept_ce && !kept_ue && (ev_ce || ev_ue);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce  <= 1'b0;
      ue  <= 1'b0;
      syn <= '0;
    end else begin
      ce <= nxt_ce;
      ue <= nxt_ue;
      if (first_hit)             syn <= ev_syn;
      else if (!nxt_ce && !nxt_ue) syn <= '0;
    end
  end

  // R8
  syn_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce || ue) && (ce || ue) && $past(clr) == 2'b00) |-> $stable(syn));

  // R8
  syn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce || ue) && !$past(ce || ue)) |-> (syn != '0));

endmodule

// File: rtl/ecc_sue_station.sv
module ecc_sue_station
  import ecc_sue_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int P  = hbits(DATA_W),
  localparam int CW = P + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_poison,
  output logic [CW-1:0]     wr_chk,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CW-1:0]     rd_chk,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CW-1:0]     out_chk,
  output logic [1:0]        out_stat,
  input  logic [1:0]        fir_clr,
  output logic              fir_ce,
  output logic              fir_ue,
  output logic [CW-1:0]     fir_syn
);
  logic [DATA_W-1:0] dec_data;
  ecc_stat_e         dec_stat;
  logic [CW-1:0]     dec_syn;
  logic [CW-1:0]     fwd_chk;
  logic              fwd_bad;
  logic              ev_ce, ev_ue;

  ecc_sue_enc #(.DATA_W(DATA_W)) u_wr_enc (
    .data_i   (wr_data),
    .poison_i (wr_poison),
    .chk_o    (wr_chk)
  );

  ecc_sue_dec #(.DATA_W(DATA_W)) u_dec (
    .data_i (rd_data),
    .chk_i  (rd_chk),
    .data_o (dec_data),
    .stat_o (dec_stat),
    .syn_o  (dec_syn)
  );

  // Uncorrectable and known-bad words leave marked for the next level.
  assign fwd_bad = (dec_stat == ST_NEWUE) || (dec_stat == ST_SUE);

  ecc_sue_enc #(.DATA_W(DATA_W)) u_fwd_enc (
    .data_i   (dec_data),
    .poison_i (fwd_bad),
    .chk_o    (fwd_chk)
  );

  assign ev_ce = rd_valid && (dec_stat == ST_FIXED);
  assign ev_ue = rd_valid && (dec_stat == ST_NEWUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chk   <= '0;
      out_stat  <= ST_CLEAN;
    end else begin
      out_valid <= rd_valid;
      if (rd_valid) begin
        out_data <= dec_data;
        out_chk  <= fwd_chk;
        out_stat <= dec_stat;
      end
    end
  end

  ecc_sue_fir #(.SYN_W(CW)) u_fir (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_ce  (ev_ce),
    .ev_ue  (ev_ue),
    .ev_syn (dec_syn),
    .clr    (fir_clr),
    .ce     (fir_ce),
    .ue     (fir_ue),
    .syn    (fir_syn)
  );

  // R8
  ce_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fir_ce) |-> (out_valid && out_stat == ST_FIXED));

  // R8
  ue_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fir_ue) |-> (out_valid && out_stat == ST_NEWUE));

  // R6
  sue_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_stat == ST_SUE && $past(fir_clr) == 2'b00)
      |-> ($stable(fir_ce) && $stable(fir_ue) && $stable(fir_syn)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(fir_clr) == 2'b00)
      |-> ($stable(fir_ce) && $stable(fir_ue) && $stable(fir_syn)));

endmodule

// File: tb/ecc_sue_station_tb_top.sv
module ecc_sue_station_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MASK = 8'h7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_poison = 1'b0;
  logic [7:0]  wr_chk;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_chk = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_chk;
  logic [1:0]  out_stat;
  logic [1:0]  fir_clr = 2'b00;
  logic        fir_ce, fir_ue;
  logic [7:0]  fir_syn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ecc_sue_station dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_data), .wr_poison(wr_poison), .wr_chk(wr_chk),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
    .out_valid(out_valid), .out_data(out_data), .out_chk(out_chk), .out_stat(out_stat),
    .fir_clr(fir_clr), .fir_ce(fir_ce), .fir_ue(fir_ue), .fir_syn(fir_syn)
  );

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Reference encoder: walk codeword positions, placing data in non-powers of two.
  function automatic logic [7:0] ref_enc(input logic [63:0] d);
    logic [6:0] h = '0;
    int k = 0;
    for (int p = 1; p <= 71; p++) begin
      if (!is_pow2(p)) begin
        if (d[k]) h ^= 7'(p);
        k++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  function automatic int ref_pos(input int i);
    int k = 0;
    for (int p = 3; p < 128; p++) begin
      if (!is_pow2(p)) begin
        if (k == i) return p;
        k++;
      end
    end
    return 0;
  endfunction

  // Expected capture for a single flip of stored bit idx ({chk, data} order).
  function automatic logic [7:0] ref_syn_flip(input int idx);
    if (idx < 64) return 8'h80 | 8'(ref_pos(idx));
    if (idx < 71) return 8'h80 | 8'(1 << (idx - 64));
    return 8'h80;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_data  = d;
    rd_chk   = c;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [1:0] st,
                            input logic [63:0] d, input logic [7:0] c);
    check(req, "out_valid", 64'(out_valid), 64'd1);
    check(req, "out_stat", 64'(out_stat), 64'(st));
    check(req, "out_data", out_data, d);
    check(req, "out_chk", 64'(out_chk), 64'(c));
  endtask

  task automatic clear_fir();
    @(negedge clk);
    fir_clr = 2'b11;
    @(negedge clk);
    fir_clr = 2'b00;
  endtask

  function automatic logic [71:0] flip72(input logic [71:0] w, input int idx);
    w[idx] = ~w[idx];
    return w;
  endfunction

  logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                            64'h0123_4567_89AB_CDEF, 64'hA5A5_5A5A_C3C3_3C3C};

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11
    check("R11", "out_valid", 64'(out_valid), 64'd0);
    check("R11", "out_stat", 64'(out_stat), 64'd0);
    check("R11", "fir_ce", 64'(fir_ce), 64'd0);
    check("R11", "fir_ue", 64'(fir_ue), 64'd0);
    check("R11", "fir_syn", 64'(fir_syn), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_encode();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr_data = pats[i]; wr_poison = 1'b0; #1;
      check("R1", "wr_chk", 64'(wr_chk), 64'(ref_enc(pats[i])));
      wr_poison = 1'b1; #1;
      check("R2", "wr_chk poison", 64'(wr_chk), 64'(ref_enc(pats[i]) ^ MASK));
    end
    for (int b = 0; b < 64; b++) begin
      wr_data = 64'd1 << b; wr_poison = 1'b0; #1;
      check("R1", "wr_chk walk", 64'(wr_chk), 64'(ref_enc(64'd1 << b)));
    end
  endtask

  task automatic t_clean();
    for (int i = 0; i < 4; i++) begin
      do_read(pats[i], ref_enc(pats[i]));
      expect_out("R3", 2'b00, pats[i], ref_enc(pats[i]));
    end
  endtask

  task automatic t_single();
    for (int i = 1; i < 4; i++) begin
      for (int idx = 0; idx < 72; idx++) begin
        logic [71:0] w = flip72({ref_enc(pats[i]), pats[i]}, idx);
        do_read(w[63:0], w[71:64]);
        expect_out("R4", 2'b01, pats[i], ref_enc(pats[i]));
      end
    end
  endtask

  task automatic t_double();
    logic [63:0] d = pats[2];
    for (int a = 0; a < 72; a++) begin
      for (int b = a + 1; b < 72; b++) begin
        logic [71:0] w = flip72(flip72({ref_enc(d), d}, a), b);
        do_read(w[63:0], w[71:64]);
        expect_out("R5", 2'b10, w[63:0], ref_enc(w[63:0]) ^ MASK);
      end
    end
  endtask

  task automatic t_sue();
    clear_fir();
    for (int i = 0; i < 4; i++) begin
      do_read(pats[i], ref_enc(pats[i]) ^ MASK);
      expect_out("R6", 2'b11, pats[i], ref_enc(pats[i]) ^ MASK);
    end
    check("R6", "fir_ce after sue", 64'(fir_ce), 64'd0);
    check("R6", "fir_ue after sue", 64'(fir_ue), 64'd0);
    check("R6", "fir_syn after sue", 64'(fir_syn), 64'd0);
  endtask

  task automatic t_sue_single();
    logic [63:0] d = pats[3];
    for (int idx = 0; idx < 72; idx++) begin
      logic [71:0] w = flip72({ref_enc(d) ^ MASK, d}, idx);
      do_read(w[63:0], w[71:64]);
      // R7: never reported as corrected
      expect_out("R7", 2'b10, w[63:0], ref_enc(w[63:0]) ^ MASK);
    end
  endtask

  task automatic t_fir();
    logic [63:0] d = pats[2];
    logic [71:0] w;
    clear_fir();
    w = flip72({ref_enc(d), d}, 5);
    do_read(w[63:0], w[71:64]);
    check("R8", "ce first", 64'(fir_ce), 64'd1);
    check("R8", "ue first", 64'(fir_ue), 64'd0);
    check("R8", "syn first", 64'(fir_syn), 64'(ref_syn_flip(5)));
    w = flip72(flip72({ref_enc(d), d}, 1), 70);
    do_read(w[63:0], w[71:64]);
    check("R8", "ue set", 64'(fir_ue), 64'd1);
    check("R8", "syn held", 64'(fir_syn), 64'(ref_syn_flip(5)));
    @(negedge clk); fir_clr = 2'b01; @(negedge clk); fir_clr = 2'b00;
    check("R9", "ce cleared", 64'(fir_ce), 64'd0);
    check("R9", "ue kept", 64'(fir_ue), 64'd1);
    check("R9", "syn kept", 64'(fir_syn), 64'(ref_syn_flip(5)));
    @(negedge clk); fir_clr = 2'b10; @(negedge clk); fir_clr = 2'b00;
    check("R9", "ue cleared", 64'(fir_ue), 64'd0);
    check("R9", "syn zero", 64'(fir_syn), 64'd0);
    w = flip72({ref_enc(d), d}, 66);
    do_read(w[63:0], w[71:64]);
    check("R8", "syn check bit", 64'(fir_syn), 64'(ref_syn_flip(66)));
    // R9: clear and new event in the same cycle; the event wins
    w = flip72({ref_enc(d), d}, 0);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = w[63:0]; rd_chk = w[71:64]; fir_clr = 2'b01;
    @(negedge clk);
    rd_valid = 1'b0; fir_clr = 2'b00;
    check("R9", "set wins", 64'(fir_ce), 64'd1);
    check("R9", "syn recaptured", 64'(fir_syn), 64'(ref_syn_flip(0)));
    check("R8", "syn bit0 pos", 64'(fir_syn), 64'h83);
  endtask

  task automatic t_idle();
    logic [63:0] d = pats[1];
    logic [71:0] w = flip72(flip72({ref_enc(d), d}, 3), 9);
    logic [7:0] syn0;
    logic ce0, ue0;
    ce0 = fir_ce; ue0 = fir_ue; syn0 = fir_syn;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = w[63:0]; rd_chk = w[71:64];
    @(negedge clk);
    check("R10", "out_valid idle", 64'(out_valid), 64'd0);
    check("R10", "ce idle", 64'(fir_ce), 64'(ce0));
    check("R10", "ue idle", 64'(fir_ue), 64'(ue0));
    check("R10", "syn idle", 64'(fir_syn), 64'(syn0));
  endtask

  initial begin
    t_reset();
    t_encode();
    t_clean();
    t_single();
    t_double();
    t_sue();
    t_sue_single();
    t_fir();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule